// File: doc/BRIEF.md
# Parallel Flash Command Interface

This block models the command front end of a byte-wide parallel NOR flash. A host drives chip-enable, output-enable and write-enable strobes, an address and a data byte. The strobes are treated as asynchronous and are brought into the system clock domain before use. The block watches the stream of write cycles for the unlock-and-command sequences that program one byte or erase one sector. It updates a small on-chip byte array to match, and it serves reads from that array whenever the bus is in a read state.

There is no reset command. A half-finished sequence is cleared by any write that does not fit the next expected step. A boot region at the top or bottom of the array can be locked by an input pin. While it is locked, program and erase operations aimed at that region are discarded without any effect. The array is a scaled-down stand-in for the full-size part, with the sector size, sector count and boot size set by parameters.

Top module: `pflash_cmd_if`

## Requirements
- R1: After reset every byte of the array reads FFh, the sequence logic is idle and `dq_oe_o` is low.
- R2: A byte is programmed by four write cycles: AAh to 5555h, 55h to 2AAAh, A0h to 5555h, then the data byte to the target address. The stored byte becomes the old byte ANDed with the data, so bits can only be cleared.
- R3: A sector is erased by six write cycles: AAh to 5555h, 55h to 2AAAh, 80h to 5555h, AAh to 5555h, 55h to 2AAAh, then 30h to any address inside the sector. Every byte of that sector becomes FFh and every other sector keeps its contents.
- R4: Command addresses are compared on address bits 14:0 only. A write that does not match the next expected step returns the sequence to idle. For example, FFh to 5555h after the two unlock cycles leaves the following write with no effect. The sequence state changes only on write cycles.
- R5: `dq_oe_o` is high only while CE is low, OE is low and WE is high, as seen two clocks earlier through the synchroniser. While it is high, `dq_o` carries the stored byte at the current address.
- R6: While CE is high, or while OE is high, `dq_oe_o` is low, whatever the other strobes do.
- R7: A write cycle runs while CE and WE are both low. Its address is taken when the later of the two falls and its data when the earlier of the two rises. CE-controlled and WE-controlled cycles behave the same, and address or data changes outside those capture points are ignored.
- R8: With `TOP_BOOT`=1, the boot region is the highest `BOOT_SECTORS` sectors; otherwise it is the lowest. While `boot_lock_i` is high, program and erase operations aimed at the boot region leave the array unchanged. Operations outside the region, and all operations while the lock is low, take effect normally.
- R9: The byte index is the low log2(`SECTOR_BYTES`·`NUM_SECTORS`) address bits. The sector number is the byte index divided by `SECTOR_BYTES`. Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low, asynchronous |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| we_ni | input | 1 | Write enable, active low, asynchronous |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data (input half of the data bus) |
| boot_lock_i | input | 1 | High locks the boot region against program and erase |
| dq_o | output | 8 | Read data (output half of the data bus) |
| dq_oe_o | output | 1 | Drive enable for the data bus; low means high-impedance |

## Verification
The checks on bus drive assume that the strobes reach the block through the two-flop synchroniser. They relate `dq_oe_o` to the raw strobe levels two clocks earlier, so they require every strobe level to be held for at least two clocks. The bench changes a strobe only on a falling clock edge and holds every level for two or more clocks. It keeps address and data steady for several clocks around each capture point. It also varies address and data away from those points, to show that they are not sampled there. The lock checks assume that `boot_lock_i` is steady during the final cycle of an operation; the bench changes the lock only between whole sequences.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PROG, ST_ESET, ST_EUNL1, ST_EUNL2
  } cmd_state_e;

  localparam int         CMD_AW    = 15;
  localparam logic [14:0] KEY_ADDR1 = 15'h5555;
  localparam logic [14:0] KEY_ADDR2 = 15'h2AAA;
  localparam logic [7:0]  KEY_DATA1 = 8'hAA;
  localparam logic [7:0]  KEY_DATA2 = 8'h55;
  localparam logic [7:0]  OP_PROG   = 8'hA0;
  localparam logic [7:0]  OP_ESETUP = 8'h80;
  localparam logic [7:0]  OP_ESECT  = 8'h30;
  localparam logic [7:0]  BYTE_ERASED = 8'hFF;
endpackage

// File: rtl/pflash_sync.sv
module pflash_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      q_o    <= RST_VAL;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pflash_bus_if.sv
module pflash_bus_if #(
  parameter int ADDR_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              rd_en_o,
  output logic              wr_evt_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  logic [2:0] strobe_s;
  logic       ce_s, oe_s, we_s;
  logic       wr_act, wr_act_q, wr_start, wr_end;

  pflash_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, oe_ni, we_ni}),
    .q_o   (strobe_s)
  );

  assign {ce_s, oe_s, we_s} = strobe_s;
  assign wr_act   = ~ce_s & ~we_s;
  assign wr_start = wr_act & ~wr_act_q;   // later falling strobe
  assign wr_end   = ~wr_act & wr_act_q;   // earlier rising strobe
  assign rd_en_o  = ~ce_s & ~oe_s & we_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      wr_evt_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_act_q <= wr_act;
      wr_evt_o <= wr_end;
      if (wr_start) wr_addr_o <= addr_i;
      if (wr_end)   wr_data_o <= data_i;
    end
  end
endmodule

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm
  import pflash_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int MEM_AW       = 10,
  parameter int OFF_W        = 4,
  parameter int NUM_SECTORS  = 64,
  parameter int BOOT_SECTORS = 4,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_evt_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              boot_lock_i,
  output logic              prog_req_o,
  output logic              erase_req_o,
  output logic [MEM_AW-1:0] op_addr_o,
  output logic [7:0]        op_data_o,
  output cmd_state_e        state_o
);
  localparam int SECT_AW = MEM_AW - OFF_W;
  localparam logic [SECT_AW-1:0] BOOT_EDGE =
    TOP_BOOT ? SECT_AW'(NUM_SECTORS - BOOT_SECTORS) : SECT_AW'(BOOT_SECTORS);

  cmd_state_e         state_q, state_d;
  logic [SECT_AW-1:0] sector;
  logic               boot_hit, blocked, at_key1, at_key2;

  assign sector  = wr_addr_i[MEM_AW-1:OFF_W];
  assign at_key1 = wr_addr_i[CMD_AW-1:0] == KEY_ADDR1;
  assign at_key2 = wr_addr_i[CMD_AW-1:0] == KEY_ADDR2;

  generate
    if (TOP_BOOT) begin : g_top_boot
      assign boot_hit = sector >= BOOT_EDGE;
    end else begin : g_bot_boot
      assign boot_hit = sector < BOOT_EDGE;
    end
  endgenerate

  assign blocked = boot_lock_i & boot_hit;

  always_comb begin
    state_d = state_q;
    if (wr_evt_i) begin
      state_d = ST_IDLE;
      unique case (state_q)
        ST_IDLE:  if (at_key1 && wr_data_i == KEY_DATA1) state_d = ST_UNL1;
        ST_UNL1:  if (at_key2 && wr_data_i == KEY_DATA2) state_d = ST_UNL2;
        ST_UNL2: begin
          if (at_key1 && wr_data_i == OP_PROG)   state_d = ST_PROG;
          if (at_key1 && wr_data_i == OP_ESETUP) state_d = ST_ESET;
        end
        ST_ESET:  if (at_key1 && wr_data_i == KEY_DATA1) state_d = ST_EUNL1;
        ST_EUNL1: if (at_key2 && wr_data_i == KEY_DATA2) state_d = ST_EUNL2;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign prog_req_o  = wr_evt_i & (state_q == ST_PROG) & ~blocked;
  assign erase_req_o = wr_evt_i & (state_q == ST_EUNL2) & (wr_data_i == OP_ESECT) & ~blocked;
  assign op_addr_o   = wr_addr_i[MEM_AW-1:0];
  assign op_data_o   = wr_data_i;
  assign state_o     = state_q;
endmodule

// File: rtl/pflash_array.sv
module pflash_array
  import pflash_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int OFF_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_req_i,
  input  logic              erase_req_i,
  input  logic [MEM_AW-1:0] op_addr_i,
  input  logic [7:0]        op_data_i,
  input  logic [MEM_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= BYTE_ERASED;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (erase_req_i && ((MEM_AW'(i) >> OFF_W) == (op_addr_i >> OFF_W)))
          mem_q[i] <= BYTE_ERASED;
        else if (prog_req_i && (MEM_AW'(i) == op_addr_i))
          mem_q[i] <= mem_q[i] & op_data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pflash_cmd_if.sv
module pflash_cmd_if
  import pflash_pkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int SECTOR_BYTES = 16,
  parameter int NUM_SECTORS  = 64,
  parameter int BOOT_SECTORS = 4,
  parameter bit TOP_BOOT     = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              boot_lock_i,
  output logic [7:0]        dq_o,
  output logic              dq_oe_o
);
  localparam int OFF_W  = $clog2(SECTOR_BYTES);
  localparam int MEM_AW = OFF_W + $clog2(NUM_SECTORS);

  logic              rd_en, wr_evt, prog_req, erase_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data, op_data, rd_data;
  logic [MEM_AW-1:0] op_addr;
  cmd_state_e        cmd_state;

  pflash_bus_if #(.ADDR_W(ADDR_W)) u_bus (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .rd_en_o  (rd_en),
    .wr_evt_o (wr_evt),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  pflash_cmd_fsm #(
    .ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .OFF_W(OFF_W),
    .NUM_SECTORS(NUM_SECTORS), .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_evt_i   (wr_evt),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .boot_lock_i(boot_lock_i),
    .prog_req_o (prog_req),
    .erase_req_o(erase_req),
    .op_addr_o  (op_addr),
    .op_data_o  (op_data),
    .state_o    (cmd_state)
  );

  pflash_array #(.MEM_AW(MEM_AW), .OFF_W(OFF_W)) u_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prog_req_i (prog_req),
    .erase_req_i(erase_req),
    .op_addr_i  (op_addr),
    .op_data_i  (op_data),
    .rd_addr_i  (addr_i[MEM_AW-1:0]),
    .rd_data_o  (rd_data)
  );

  assign dq_oe_o = rd_en;
  assign dq_o    = rd_en ? rd_data : '0;
endmodule

// File: rtl/pflash_cmd_if_chk.sv
module pflash_cmd_if_chk #(
  parameter int MEM_AW       = 10,
  parameter int OFF_W        = 4,
  parameter int NUM_SECTORS  = 64,
  parameter int BOOT_SECTORS = 4,
  parameter bit TOP_BOOT     = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              oe_ni,
  input logic              we_ni,
  input logic              boot_lock_i,
  input logic              dq_oe_o,
  input logic              wr_evt,
  input logic [2:0]        state,
  input logic              prog_req,
  input logic              erase_req,
  input logic [MEM_AW-1:0] op_addr
);
  function automatic bit in_boot(logic [MEM_AW-1:0] a);
    int sec;
    sec = int'(a >> OFF_W);
    return TOP_BOOT ? (sec >= NUM_SECTORS - BOOT_SECTORS) : (sec < BOOT_SECTORS);
  endfunction

  a_r5_read_needs_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!$past(ce_ni, 2) && !$past(oe_ni, 2) && $past(we_ni, 2)));

  a_r6_standby_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ce_ni, 2) || $past(oe_ni, 2)) |-> !dq_oe_o);

  a_r4_state_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_evt |=> $stable(state));

  a_r2_prog_ends_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req |=> (state == 3'd0));

  a_r3_erase_ends_seq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req |=> (state == 3'd0));

  a_r8_lock_blocks_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_lock_i && prog_req) |-> !in_boot(op_addr));

  a_r8_lock_blocks_erase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_lock_i && erase_req) |-> !in_boot(op_addr));
endmodule

bind pflash_cmd_if pflash_cmd_if_chk #(
  .MEM_AW(MEM_AW), .OFF_W(OFF_W), .NUM_SECTORS(NUM_SECTORS),
  .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(TOP_BOOT)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .we_ni      (we_ni),
  .boot_lock_i(boot_lock_i),
  .dq_oe_o    (dq_oe_o),
  .wr_evt     (wr_evt),
  .state      (cmd_state),
  .prog_req   (prog_req),
  .erase_req  (erase_req),
  .op_addr    (op_addr)
);

// File: tb/pflash_cmd_if_bench.sv
module pflash_cmd_if_bench;
  localparam int CLK_PERIOD   = 10;
  localparam int ADDR_W       = 18;
  localparam int SECTOR_BYTES = 16;
  localparam int NUM_SECTORS  = 64;
  localparam int BOOT_SECTORS = 4;
  localparam int DEPTH        = SECTOR_BYTES * NUM_SECTORS;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        data = '0;
  logic              lock = 1'b0;
  logic [7:0]        dq;
  logic              dq_oe;

  logic [7:0] model [DEPTH];
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pflash_cmd_if #(
    .ADDR_W(ADDR_W), .SECTOR_BYTES(SECTOR_BYTES), .NUM_SECTORS(NUM_SECTORS),
    .BOOT_SECTORS(BOOT_SECTORS), .TOP_BOOT(1'b1)
  ) u_pflash_cmd_if (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(data), .boot_lock_i(lock), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  function automatic bit boot_hit(int idx);
    return (idx / SECTOR_BYTES) >= NUM_SECTORS - BOOT_SECTORS;
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [ADDR_W-1:0] a, logic [7:0] d, bit ce_ctl);
    @(negedge clk);
    addr = a; data = ~d;
    if (ce_ctl) begin we_n = 1'b0; tick(2); ce_n = 1'b0; end
    else        begin ce_n = 1'b0; tick(2); we_n = 1'b0; end
    tick(4);
    addr = a ^ 18'h0_0155;   // must not be sampled (R7)
    data = d;
    tick(2);
    if (ce_ctl) begin ce_n = 1'b1; tick(4); we_n = 1'b1; end
    else        begin we_n = 1'b1; tick(4); ce_n = 1'b1; end
    data = ~d;               // must not be sampled (R7)
    tick(2);
  endtask

  task automatic rd_chk(string req, logic [ADDR_W-1:0] a);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    tick(4);
    chk({req, " oe"}, {7'd0, dq_oe}, 8'd1);
    chk({req, " data"}, dq, model[int'(a) % DEPTH]);
    oe_n = 1'b1; ce_n = 1'b1;
    tick(3);
  endtask

  task automatic bus_state(string req, logic c, logic o, logic w, logic exp);
    @(negedge clk);
    ce_n = c; oe_n = o; we_n = w;
    tick(4);
    chk(req, {7'd0, dq_oe}, {7'd0, exp});
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    tick(3);
  endtask

  task automatic do_prog(logic [ADDR_W-1:0] a, logic [7:0] d, bit ce_ctl);
    int idx = int'(a) % DEPTH;
    bus_wr(18'h05555, 8'hAA, ce_ctl);
    bus_wr(18'h02AAA, 8'h55, ce_ctl);
    bus_wr(18'h05555, 8'hA0, ce_ctl);
    bus_wr(a, d, ce_ctl);
    if (!(lock && boot_hit(idx))) model[idx] = model[idx] & d;
  endtask

  task automatic do_erase(logic [ADDR_W-1:0] a);
    int idx = int'(a) % DEPTH;
    int base = (idx / SECTOR_BYTES) * SECTOR_BYTES;
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(18'h05555, 8'h80, 1'b0);
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(a, 8'h30, 1'b0);
    if (!(lock && boot_hit(idx)))
      for (int k = 0; k < SECTOR_BYTES; k++) model[base + k] = 8'hFF;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A17));
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    tick(3);
    chk("R1 reset oe", {7'd0, dq_oe}, 8'd0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 idle oe", {7'd0, dq_oe}, 8'd0);
    rd_chk("R1", 18'h00000);
    rd_chk("R1", 18'h003FF);

    // R6 / R5 bus states
    bus_state("R6 standby", 1'b1, 1'b0, 1'b1, 1'b0);
    bus_state("R6 out-dis", 1'b0, 1'b1, 1'b1, 1'b0);
    bus_state("R5 we low", 1'b0, 1'b0, 1'b0, 1'b0);
    bus_state("R5 read", 1'b0, 1'b0, 1'b1, 1'b1);

    // R2 program, AND semantics; R7 WE- and CE-controlled
    do_prog(18'h00123, 8'h5A, 1'b0);
    rd_chk("R2 prog", 18'h00123);
    do_prog(18'h00123, 8'h0F, 1'b1);
    rd_chk("R7 ce-ctl", 18'h00123);
    chk("R2 and", model[291], 8'h0A);
    // R9 aliasing of upper bits
    do_prog(18'h20044, 8'h3C, 1'b1);
    rd_chk("R9 alias", 18'h00044);

    // R4 abort: FF after unlocks, then a plain write must not program
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(18'h05555, 8'hFF, 1'b0);
    bus_wr(18'h00200, 8'h00, 1'b0);
    rd_chk("R4 abort", 18'h00200);
    // R4 bad key address, then wrong erase command
    bus_wr(18'h05554, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(18'h05555, 8'hA0, 1'b0);
    bus_wr(18'h00201, 8'h00, 1'b0);
    rd_chk("R4 bad key", 18'h00201);
    do_prog(18'h00050, 8'h11, 1'b0);
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(18'h05555, 8'h80, 1'b0);
    bus_wr(18'h05555, 8'hAA, 1'b0);
    bus_wr(18'h02AAA, 8'h55, 1'b0);
    bus_wr(18'h00050, 8'h31, 1'b0);
    rd_chk("R4 bad erase", 18'h00050);
    // R4 upper address bits ignored in command compare
    do_prog(18'h00301, 8'h00, 1'b0);
    bus_wr(18'h3D555, 8'hAA, 1'b0);
    bus_wr(18'h3AAAA, 8'h55, 1'b0);
    bus_wr(18'h3D555, 8'hA0, 1'b0);
    bus_wr(18'h00302, 8'h77, 1'b0);
    model[770] = 8'h77;
    rd_chk("R4 key bits", 18'h00302);

    // R3 erase sector 5 only
    do_prog(18'h0004F, 8'h01, 1'b0);
    do_prog(18'h00050, 8'h02, 1'b0);
    do_prog(18'h0005F, 8'h03, 1'b0);
    do_prog(18'h00060, 8'h04, 1'b0);
    do_erase(18'h00057);
    rd_chk("R3 erased lo", 18'h00050);
    rd_chk("R3 erased hi", 18'h0005F);
    rd_chk("R3 below", 18'h0004F);
    rd_chk("R3 above", 18'h00060);
    chk("R3 value", model[80], 8'hFF);

    // R8 boot lock
    lock = 1'b1;
    do_prog(18'h003C5, 8'h00, 1'b0);
    rd_chk("R8 locked prog", 18'h003C5);
    do_prog(18'h003B0, 8'h00, 1'b0);
    rd_chk("R8 outside", 18'h003B0);
    lock = 1'b0;
    do_prog(18'h003E1, 8'h00, 1'b1);
    rd_chk("R8 unlocked prog", 18'h003E1);
    lock = 1'b1;
    do_erase(18'h003E0);
    rd_chk("R8 locked erase", 18'h003E1);
    lock = 1'b0;
    do_erase(18'h003E0);
    rd_chk("R8 unlocked erase", 18'h003E1);

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [ADDR_W-1:0] a;
      int sel = $urandom % 8;
      a = ADDR_W'($urandom);
      if ($urandom % 4 == 0) a[9:6] = 4'hF;
      if ($urandom % 4 == 0) lock = ~lock;
      if (sel == 0) begin
        do_erase(a);
        rd_chk("R3 rand", a);
      end else begin
        do_prog(a, 8'($urandom), 1'($urandom));
        rd_chk(lock ? "R8 rand" : "R2 rand", a);
      end
    end

    // R9 full sweep against model
    lock = 1'b0;
    for (int i = 0; i < DEPTH; i++) rd_chk("R9 sweep", ADDR_W'(i));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule